// File: doc/BRIEF.md
# Chained Multiply-Add Vector Pipeline

The block computes, for every element k of a vector, `res[k] = a[k] * b[k] + c[k]` with two deep, fully pipelined integer functional units: a multiplier whose results form an intermediate vector, and an adder that takes that intermediate vector together with a second operand. A sequencer accepts a start request with a vector length and a mode bit. It issues the multiply over all elements, one per clock, and then feeds the dependent add.

In chained mode each product goes straight into the adder in the cycle it leaves the multiplier, so the two operations overlap element by element. In serial mode the products are first collected in an internal vector register. The add begins only once the last product has been written, which models two back-to-back groups of instructions. Operands are read from the surrounding register file through index ports: the block shows the element index it reads, and the operand values come back in the same cycle. Each result leaves in index order together with its index. At the end the block reports how many cycles the operation took.

Top module: `vchain_unit`

## Requirements
- R1: After reset `busy_o`, `done_o`, `res_vld_o`, `mul_rd_o` and `add_rd_o` are 0 and `cycles_o` is 0.
- R2: Every result equals `(a*b + c) mod 2^DATA_W`. Here a and b are the values on `a_i`/`b_i` while `mul_idx_o` shows that element, and c is the value on `c_i` while `add_idx_o` shows it.
- R3: Counting cycle 0 as the cycle after the clock edge that accepts a start, the multiplier reads element k in cycle k (`mul_rd_o`=1, `mul_idx_o`=k) for k = 0..n-1, and it reads nothing else during the operation.
- R4: Results leave on `res_vld_o` one per clock, in ascending index order starting at 0, each tagged with its index on `res_idx_o`.
- R5: With `chain_i`=1 (chained) the adder reads element k in cycle MUL_LAT+k and the result k appears in cycle MUL_LAT+ADD_LAT+k. `cycles_o` then reports MUL_LAT+ADD_LAT+n-1.
- R6: With `chain_i`=0 (serial) the adder reads nothing until all n products are complete. It then reads element k in cycle n+MUL_LAT+k, result k appears in cycle n+MUL_LAT+ADD_LAT+k, and `cycles_o` reports (MUL_LAT+n-1)+(ADD_LAT+n-1)+1.
- R7: A start while `busy_o`=1 is ignored: mode, length, results and cycle count of the running operation are unchanged.
- R8: A start with length 0 is ignored (`busy_o` stays 0). A length above MAX_LEN runs MAX_LEN elements.
- R9: `done_o` is a one-cycle pulse in the cycle after the last result, with `busy_o`=0. From then on `cycles_o` holds its value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| chain_i | input | 1 | 1 = chained, 0 = serial; sampled with start |
| len_i | input | LEN_W | Vector length, sampled with start |
| mul_rd_o | output | 1 | Multiplier reads an element this cycle |
| mul_idx_o | output | IDX_W | Index of the element read for the multiplier |
| a_i | input | DATA_W | First multiplier operand for `mul_idx_o` |
| b_i | input | DATA_W | Second multiplier operand for `mul_idx_o` |
| add_rd_o | output | 1 | Adder reads an element this cycle |
| add_idx_o | output | IDX_W | Index of the element read for the adder |
| c_i | input | DATA_W | Adder operand for `add_idx_o` |
| res_vld_o | output | 1 | Result valid |
| res_idx_o | output | IDX_W | Element index of the result |
| res_data_o | output | DATA_W | Result value |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | CNT_W | Measured cycle count of the last operation |

## Verification
The bench builds the block with MAX_LEN=16 and DATA_W=8 and keeps the latencies at 7 and 6. This makes it possible to sweep every legal length in both modes and to check every element and its exact arrival cycle. Multiplying 8-bit operands also exercises the truncation of products and sums. A length of 20 on the 5-bit length port drives the clamp, and length 0 drives the ignored start. Starts injected mid-operation with a different mode and length probe whether a running operation is disturbed.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_CHAIN  = 1'b1
  } vc_mode_e;

  // Expected end-to-end compute time (index of the last result cycle).
  function automatic int chain_cycles(int n, int mul_lat, int add_lat);
    return mul_lat + add_lat + n - 1;
  endfunction

  function automatic int serial_cycles(int n, int mul_lat, int add_lat);
    return (mul_lat + n - 1) + (add_lat + n - 1) + 1;
  endfunction

endpackage

// File: rtl/vc_pipe.sv
module vc_pipe #(
  parameter int LAT = 4,
  parameter int W   = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] pay_i,
  output logic         vld_o,
  output logic [W-1:0] pay_o
);

  logic [LAT-1:0] vld_q;
  logic [W-1:0]   pay_q [LAT];

  generate
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic         vld_d;
      logic [W-1:0] pay_d;
      if (s == 0) begin : g_head
        assign vld_d = vld_i;
        assign pay_d = pay_i;
      end else begin : g_body
        assign vld_d = vld_q[s-1];
        assign pay_d = pay_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[s] <= 1'b0;
          pay_q[s] <= '0;
        end else begin
          vld_q[s] <= vld_d;
          pay_q[s] <= pay_d;
        end
      end
    end
  endgenerate

  assign vld_o = vld_q[LAT-1];
  assign pay_o = pay_q[LAT-1];

endmodule

// File: rtl/vc_vreg.sv
module vc_vreg #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/vc_seq.sv
module vc_seq
  import vc_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = 7,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             chain_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             mul_out_vld_i,
  input  logic [IDX_W-1:0] mul_out_idx_i,
  input  logic             add_out_vld_i,
  input  logic [IDX_W-1:0] add_out_idx_i,
  output logic             busy_o,
  output vc_mode_e         mode_o,
  output logic             mul_iss_o,
  output logic [IDX_W-1:0] mul_idx_o,
  output logic             ser_iss_o,
  output logic [IDX_W-1:0] ser_idx_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cycles_o
);

  localparam logic [LEN_W-1:0] MaxLen = LEN_W'(MAX_LEN);

  logic             busy_q, mul_on_q, ser_on_q, done_q;
  vc_mode_e         mode_q;
  logic [IDX_W-1:0] last_q, mul_cnt_q, ser_cnt_q;
  logic [CNT_W-1:0] cnt_q, cycles_q;
  logic [LEN_W-1:0] len_eff;
  logic             accept, mul_last_out, add_last_out;

  assign len_eff      = (len_i > MaxLen) ? MaxLen : len_i;
  assign accept       = start_i && !busy_q && (len_i != '0);
  assign mul_last_out = busy_q && mul_out_vld_i && (mul_out_idx_i == last_q);
  assign add_last_out = busy_q && add_out_vld_i && (add_out_idx_i == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      mode_q    <= MODE_SERIAL;
      last_q    <= '0;
      mul_on_q  <= 1'b0;
      mul_cnt_q <= '0;
      ser_on_q  <= 1'b0;
      ser_cnt_q <= '0;
      cnt_q     <= '0;
      cycles_q  <= '0;
      done_q    <= 1'b0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      mode_q    <= vc_mode_e'(chain_i);
      last_q    <= IDX_W'(len_eff - LEN_W'(1));
      mul_on_q  <= 1'b1;
      mul_cnt_q <= '0;
      ser_on_q  <= 1'b0;
      ser_cnt_q <= '0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) cnt_q <= cnt_q + CNT_W'(1);
      if (mul_on_q) begin
        if (mul_cnt_q == last_q) mul_on_q <= 1'b0;
        else                     mul_cnt_q <= mul_cnt_q + IDX_W'(1);
      end
      if (ser_on_q) begin
        if (ser_cnt_q == last_q) ser_on_q <= 1'b0;
        else                     ser_cnt_q <= ser_cnt_q + IDX_W'(1);
      end
      // serial mode: second unit waits for the final product
      if (mode_q == MODE_SERIAL && mul_last_out) ser_on_q <= 1'b1;
      if (add_last_out) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        cycles_q <= cnt_q;
      end
    end
  end

  assign busy_o    = busy_q;
  assign mode_o    = mode_q;
  assign mul_iss_o = mul_on_q;
  assign mul_idx_o = mul_cnt_q;
  assign ser_iss_o = ser_on_q;
  assign ser_idx_o = ser_cnt_q;
  assign done_o    = done_q;
  assign cycles_o  = cycles_q;

endmodule

// File: rtl/vchain_unit.sv
module vchain_unit
  import vc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MAX_LEN = 64,
  parameter int MUL_LAT = 7,
  parameter int ADD_LAT = 6,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int CNT_W   = $clog2(2 * MAX_LEN + MUL_LAT + ADD_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chain_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              mul_rd_o,
  output logic [IDX_W-1:0]  mul_idx_o,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              add_rd_o,
  output logic [IDX_W-1:0]  add_idx_o,
  input  logic [DATA_W-1:0] c_i,
  output logic              res_vld_o,
  output logic [IDX_W-1:0]  res_idx_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cycles_o
);

  localparam int PW = IDX_W + DATA_W;

  vc_mode_e          mode;
  logic              mul_iss, ser_iss;
  logic [IDX_W-1:0]  mul_idx, ser_idx;
  logic [DATA_W-1:0] prod, sum, add_src, vreg_rd;
  logic              mul_out_vld, add_out_vld;
  logic [PW-1:0]     mul_out_pay, add_out_pay;
  logic [IDX_W-1:0]  mul_out_idx, add_out_idx;
  logic [DATA_W-1:0] mul_out_data;

  vc_seq #(
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .chain_i      (chain_i),
    .len_i        (len_i),
    .mul_out_vld_i(mul_out_vld),
    .mul_out_idx_i(mul_out_idx),
    .add_out_vld_i(add_out_vld),
    .add_out_idx_i(add_out_idx),
    .busy_o       (busy_o),
    .mode_o       (mode),
    .mul_iss_o    (mul_iss),
    .mul_idx_o    (mul_idx),
    .ser_iss_o    (ser_iss),
    .ser_idx_o    (ser_idx),
    .done_o       (done_o),
    .cycles_o     (cycles_o)
  );

  // multiply unit
  assign prod = a_i * b_i;

  vc_pipe #(.LAT(MUL_LAT), .W(PW)) i_mul_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (mul_iss),
    .pay_i ({mul_idx, prod}),
    .vld_o (mul_out_vld),
    .pay_o (mul_out_pay)
  );

  assign mul_out_idx  = mul_out_pay[PW-1:DATA_W];
  assign mul_out_data = mul_out_pay[DATA_W-1:0];

  // intermediate vector register
  vc_vreg #(.DEPTH(MAX_LEN), .W(DATA_W), .AW(IDX_W)) i_vreg (
    .clk_i  (clk_i),
    .we_i   (mul_out_vld),
    .waddr_i(mul_out_idx),
    .wdata_i(mul_out_data),
    .raddr_i(ser_idx),
    .rdata_o(vreg_rd)
  );

  // add unit: forwarded product when chained, stored vector when serial
  assign add_rd_o  = (mode == MODE_CHAIN) ? mul_out_vld : ser_iss;
  assign add_idx_o = (mode == MODE_CHAIN) ? mul_out_idx : ser_idx;
  assign add_src   = (mode == MODE_CHAIN) ? mul_out_data : vreg_rd;
  assign sum       = add_src + c_i;

  vc_pipe #(.LAT(ADD_LAT), .W(PW)) i_add_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (add_rd_o),
    .pay_i ({add_idx_o, sum}),
    .vld_o (add_out_vld),
    .pay_o (add_out_pay)
  );

  assign add_out_idx = add_out_pay[PW-1:DATA_W];

  assign mul_rd_o   = mul_iss;
  assign mul_idx_o  = mul_idx;
  assign res_vld_o  = add_out_vld;
  assign res_idx_o  = add_out_idx;
  assign res_data_o = add_out_pay[DATA_W-1:0];

endmodule

// File: rtl/vc_chk.sv
module vc_chk
  import vc_pkg::*;
#(
  parameter int MUL_LAT = 7,
  parameter int ADD_LAT = 6,
  parameter int LEN_W   = 7,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input vc_mode_e         mode,
  input logic             mul_rd_o,
  input logic [IDX_W-1:0] mul_idx_o,
  input logic             add_rd_o,
  input logic             res_vld_o,
  input logic [IDX_W-1:0] res_idx_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] cycles_o
);

  int res_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_seen <= 0;
    else if (done_o)    res_seen <= 0;
    else if (res_vld_o) res_seen <= res_seen + 1;
  end

  AST_ISSUE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_rd_o && $past(mul_rd_o) |-> mul_idx_o == $past(mul_idx_o) + IDX_W'(1)); // R3
  AST_RES_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_vld_o && $past(res_vld_o) |-> res_idx_o == $past(res_idx_o) + IDX_W'(1)); // R4
  AST_RES_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_vld_o) |-> res_idx_o == '0); // R4
  AST_CHAIN_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode == MODE_CHAIN |->
      int'(cycles_o) == chain_cycles(res_seen, MUL_LAT, ADD_LAT)); // R5
  AST_SERIAL_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode == MODE_SERIAL |->
      int'(cycles_o) == serial_cycles(res_seen, MUL_LAT, ADD_LAT)); // R6
  AST_SERIAL_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_SERIAL && add_rd_o |-> !mul_rd_o); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R7
  AST_LEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && len_i == '0 |=> !busy_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_CYCLES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(cycles_o) || done_o); // R9

endmodule

bind vchain_unit vc_chk #(
  .MUL_LAT(MUL_LAT),
  .ADD_LAT(ADD_LAT),
  .LEN_W  (LEN_W),
  .IDX_W  (IDX_W),
  .CNT_W  (CNT_W)
) i_vc_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .len_i    (len_i),
  .mode     (mode),
  .mul_rd_o (mul_rd_o),
  .mul_idx_o(mul_idx_o),
  .add_rd_o (add_rd_o),
  .res_vld_o(res_vld_o),
  .res_idx_o(res_idx_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .cycles_o (cycles_o)
);

// File: tb/test_vchain_unit.sv
module test_vchain_unit;

  localparam int DW    = 8;
  localparam int MAXL  = 16;
  localparam int ML    = 7;
  localparam int AL    = 6;
  localparam int LEN_W = $clog2(MAXL + 1);
  localparam int IDX_W = $clog2(MAXL);
  localparam int CNT_W = $clog2(2 * MAXL + ML + AL + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             chain = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic             mul_rd_o, add_rd_o, res_vld_o, busy_o, done_o;
  logic [IDX_W-1:0] mul_idx_o, add_idx_o, res_idx_o;
  logic [DW-1:0]    a_i, b_i, c_i, res_data_o;
  logic [CNT_W-1:0] cycles_o;

  int sd = 0;
  int tests = 0;
  int fails = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  // operand register file model, indexed by the block
  function automatic int fa(int k, int s); return (k * 3 + s) & 8'hFF; endfunction
  function automatic int fb(int k, int s); return (k + 5 + 7 * s) & 8'hFF; endfunction
  function automatic int fc(int k, int s); return (k ^ (s * 11)) & 8'hFF; endfunction

  assign a_i = DW'(fa(int'(mul_idx_o), sd));
  assign b_i = DW'(fb(int'(mul_idx_o), sd));
  assign c_i = DW'(fc(int'(add_idx_o), sd));

  vchain_unit #(
    .DATA_W(DW), .MAX_LEN(MAXL), .MUL_LAT(ML), .ADD_LAT(AL)
  ) i_vchain_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chain_i(chain), .len_i(len),
    .mul_rd_o(mul_rd_o), .mul_idx_o(mul_idx_o), .a_i(a_i), .b_i(b_i),
    .add_rd_o(add_rd_o), .add_idx_o(add_idx_o), .c_i(c_i),
    .res_vld_o(res_vld_o), .res_idx_o(res_idx_o), .res_data_o(res_data_o),
    .busy_o(busy_o), .done_o(done_o), .cycles_o(cycles_o)
  );

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(int n_req, bit ch, int s, bit inject);
    int n = (n_req > MAXL) ? MAXL : n_req;
    int k = 0;
    int first_add = -1;
    int bad_issue = 0;
    bit got_done = 1'b0;
    sd = s;
    @(negedge clk);
    start = 1'b1; chain = ch; len = LEN_W'(n_req);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 200 && !got_done; c++) begin
      if (inject && c == 3) begin start = 1'b1; chain = !ch; len = LEN_W'(5); end
      if (inject && c == 4) start = 1'b0;
      if (mul_rd_o != (c < n) || (c < n && int'(mul_idx_o) != c)) bad_issue++;
      if (add_rd_o && first_add < 0) first_add = c;
      if (res_vld_o) begin
        int exp_cyc = ch ? ML + AL + k : n + ML + AL + k;
        int exp_d = (fa(k, s) * fb(k, s) + fc(k, s)) & 8'hFF;
        check(int'(res_idx_o) == k, "R4 result index", int'(res_idx_o), k);
        check(int'(res_data_o) == exp_d, "R2 result data", int'(res_data_o), exp_d);
        check(c == exp_cyc, ch ? "R5 result cycle" : "R6 result cycle", c, exp_cyc);
        k++;
      end
      if (done_o) begin
        int exp_c = ch ? ML + AL + n - 1 : (ML + n - 1) + (AL + n - 1) + 1;
        got_done = 1'b1;
        check(int'(cycles_o) == exp_c, ch ? "R5 cycles" : "R6 cycles",
              int'(cycles_o), exp_c);
        check(busy_o == 1'b0, "R9 idle at done", int'(busy_o), 0);
        check(k == n, inject ? "R7 result count" : "R4 result count", k, n);
      end else begin
        @(negedge clk);
      end
    end
    check(got_done, "R9 done seen", int'(got_done), 1);
    check(bad_issue == 0, "R3 multiplier issue", bad_issue, 0);
    check(first_add == (ch ? ML : n + ML), ch ? "R5 first add" : "R6 first add",
          first_add, ch ? ML : n + ML);
    @(negedge clk);
    check(done_o == 1'b0, "R9 done pulse", int'(done_o), 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      tests++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int held;
    bit any;
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && res_vld_o == 0, "R1 reset flags",
          int'({busy_o, done_o, res_vld_o}), 0);
    check(mul_rd_o == 0 && add_rd_o == 0, "R1 reset reads",
          int'({mul_rd_o, add_rd_o}), 0);
    check(cycles_o == '0, "R1 reset cycles", int'(cycles_o), 0);
    rst_n = 1'b1;

    for (int n = 1; n <= MAXL; n++) begin
      run_op(n, 1'b1, n, 1'b0);
      run_op(n, 1'b0, n + 17, 1'b0);
    end

    // start during an operation
    run_op(9, 1'b1, 3, 1'b1);
    run_op(6, 1'b0, 4, 1'b1);

    // length clamp
    run_op(20, 1'b1, 5, 1'b0);
    run_op(20, 1'b0, 6, 1'b0);

    // length zero
    held = int'(cycles_o);
    @(negedge clk);
    start = 1'b1; len = '0; chain = 1'b1;
    @(negedge clk);
    start = 1'b0;
    any = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (busy_o || res_vld_o || mul_rd_o) any = 1'b1;
      @(negedge clk);
    end
    check(!any, "R8 zero length ignored", int'(any), 0);
    check(int'(cycles_o) == held, "R9 cycles held", int'(cycles_o), held);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule